// File: doc/BRIEF.md
# Up/Down Event Timer with Selectable Direction

The block is a count register advanced by rising edges of an external clock line. That line is first brought into the system clock domain through a multi-flop synchronizer. A rising-edge detector then turns each low-to-high transition into a single-cycle advance. Falling edges are not counted. There is no asynchronous counting path: every count step happens on a system clock edge.

The count moves up or down. The direction comes either from a direction line driven from outside or from a control bit written by software, and a source-select input chooses between them. Counting up, the register wraps to zero on the step after it equals the period value. Counting down, it reloads the period value on the step after it reaches zero. Each wrap or reload raises a one-cycle event pulse.

The timer runs only while the 3-bit mode input holds the timer code. Under any other code the count keeps its value, so a controller can switch the block to another use and back without losing the count. A synchronous clear input forces the count to zero.

Top module: `updn_timer`

## Requirements
- R1: A rising edge on `ext_clk_i` changes the count on the third rising edge of `clk_i` after the input rises (two synchronizer stages plus one edge-detect register). The count is still unchanged after the second edge. A falling edge on `ext_clk_i` never changes the count.
- R2: When counting up, each counted edge adds one to the count. If the count equals `period_i` when the edge is counted, the count becomes zero instead.
- R3: When counting down, each counted edge subtracts one from the count. If the count is zero when the edge is counted, the count becomes `period_i` instead.
- R4: `event_o` is high for exactly one `clk_i` cycle. That cycle is the one in which the count takes its wrapped value (zero when counting up) or its reloaded value (`period_i` when counting down). At every other time `event_o` is low.
- R5: With `dir_src_i` = 1, the synchronized `ext_dir_i` sets the direction (1 = up, 0 = down), and `dir_bit_i` has no effect.
- R6: With `dir_src_i` = 0, `dir_bit_i` sets the direction (1 = up, 0 = down), and `ext_dir_i` has no effect.
- R7: The count advances only while `mode_i` = 3'b001. For each of the other seven codes, edges on `ext_clk_i` leave the count unchanged and `event_o` stays low.
- R8: Changing `mode_i` away from 3'b001 and back leaves the count unchanged, and counting resumes from that value.
- R9: `clear_i` high at a `clk_i` edge sets the count to zero and `event_o` to low on that edge. This takes priority over any counted edge.
- R10: While `rst_ni` is low, the count is zero and `event_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous clear of the count |
| mode_i | input | 3 | Operating mode; 3'b001 enables the timer |
| dir_bit_i | input | 1 | Software direction bit, 1 = up |
| dir_src_i | input | 1 | Direction source: 1 = external pin, 0 = software bit |
| ext_clk_i | input | 1 | External count clock, asynchronous |
| ext_dir_i | input | 1 | External direction line, asynchronous, 1 = up |
| period_i | input | WIDTH | Period value for match and reload |
| count_o | output | WIDTH | Current count |
| event_o | output | 1 | One-cycle pulse on wrap or reload |

## Verification
The bench builds the timer with WIDTH = 4, which keeps the full range of periods within reach. For every period from 0 to 15, it counts up and then down through more than two complete cycles, so each wrap, reload and event pulse is reached at every possible period value. It also sets the unused direction source to the opposite direction, walks all eight mode codes, and applies clear at a nonzero count. Each of these cases is compared against a count model kept in the bench.

// File: rtl/updn_timer_pkg.sv
package updn_timer_pkg;
  localparam logic [2:0] MODE_TIMER = 3'b001;
  typedef enum logic {DIR_DOWN = 1'b0, DIR_UP = 1'b1} dir_e;
endpackage

// File: rtl/ut_sync.sv
module ut_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stage_q[s] <= '0;
      end else if (s == 0) begin
        stage_q[s] <= d_i;
      end else begin
        stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/ut_edge.sv
module ut_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;

  // a rise cannot repeat on consecutive cycles
  assert_tick_single_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/ut_core.sv
module ut_core
  import updn_timer_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             run_i,
  input  logic             tick_i,
  input  dir_e             dir_i,
  input  logic [WIDTH-1:0] period_i,
  output logic [WIDTH-1:0] count_o,
  output logic             event_o
);
  localparam logic [WIDTH-1:0] ZERO = '0;
  localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);

  logic [WIDTH-1:0] count_q, count_d;
  logic             event_q, event_d;
  logic             step;

  assign step = run_i & tick_i;

  always_comb begin
    count_d = count_q;
    event_d = 1'b0;
    if (clear_i) begin
      count_d = ZERO;
    end else if (step) begin
      if (dir_i == DIR_UP) begin
        if (count_q == period_i) begin
          count_d = ZERO;
          event_d = 1'b1;
        end else begin
          count_d = count_q + ONE;
        end
      end else begin
        if (count_q == ZERO) begin
          count_d = period_i;
          event_d = 1'b1;
        end else begin
          count_d = count_q - ONE;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= ZERO;
      event_q <= 1'b0;
    end else begin
      count_q <= count_d;
      event_q <= event_d;
    end
  end

  assign count_o = count_q;
  assign event_o = event_q;

  assert_up_wrap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && step && dir_i == DIR_UP && count_q == period_i)
      |=> (count_q == ZERO && event_q));

  assert_down_reload_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && step && dir_i == DIR_DOWN && count_q == ZERO)
      |=> (count_q == $past(period_i) && event_q));

  assert_event_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    event_q |=> !event_q);

  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && !run_i) |=> ($stable(count_q) && !event_q));

  assert_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (count_q == ZERO && !event_q));
endmodule

// File: rtl/updn_timer.sv
module updn_timer
  import updn_timer_pkg::*;
#(
  parameter int WIDTH       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic [2:0]       mode_i,
  input  logic             dir_bit_i,
  input  logic             dir_src_i,
  input  logic             ext_clk_i,
  input  logic             ext_dir_i,
  input  logic [WIDTH-1:0] period_i,
  output logic [WIDTH-1:0] count_o,
  output logic             event_o
);
  logic [1:0] raw_in, sync_out;
  logic       tick;
  logic       run;
  dir_e       dir;

  assign raw_in = {ext_dir_i, ext_clk_i};

  ut_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw_in),
    .q_o   (sync_out)
  );

  ut_edge u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (sync_out[0]),
    .rise_o(tick)
  );

  assign run = (mode_i == MODE_TIMER);
  assign dir = dir_e'(dir_src_i ? sync_out[1] : dir_bit_i);

  ut_core #(.WIDTH(WIDTH)) u_core (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear_i),
    .run_i   (run),
    .tick_i  (tick),
    .dir_i   (dir),
    .period_i(period_i),
    .count_o (count_o),
    .event_o (event_o)
  );

  assert_reset_R10: assert property (@(posedge clk_i)
    !rst_ni |-> (count_o == '0 && !event_o));
endmodule

// File: tb/updn_timer_test.sv
module updn_timer_test;
  localparam int W      = 4;
  localparam int CLK_NS = 10;
  localparam int MAXV   = (1 << W) - 1;

  logic         clk_i = 0, rst_ni = 0, clear_i = 0;
  logic [2:0]   mode_i = 3'b001;
  logic         dir_bit_i = 1, dir_src_i = 0, ext_clk_i = 0, ext_dir_i = 0;
  logic [W-1:0] period_i = '0;
  logic [W-1:0] count_o;
  logic         event_o;

  int total = 0, bad = 0;
  int cnt = 0;

  always #(CLK_NS/2) clk_i = ~clk_i;

  updn_timer #(.WIDTH(W), .SYNC_STAGES(2)) uut (
    .clk_i, .rst_ni, .clear_i, .mode_i, .dir_bit_i, .dir_src_i,
    .ext_clk_i, .ext_dir_i, .period_i, .count_o, .event_o
  );

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one external clock pulse; up = direction the model expects, active = counting expected
  task automatic pulse(bit up, bit active, string req);
    int nxt; bit ev;
    nxt = cnt; ev = 0;
    if (active) begin
      if (up) begin
        if (cnt == int'(period_i)) begin nxt = 0; ev = 1; end else nxt = cnt + 1;
      end else begin
        if (cnt == 0) begin nxt = int'(period_i); ev = 1; end else nxt = cnt - 1;
      end
    end
    @(negedge clk_i) ext_clk_i = 1;
    @(negedge clk_i);
    @(negedge clk_i);
    check({req, " R1 latency"}, int'(count_o), cnt);
    @(negedge clk_i);
    check({req, " count"}, int'(count_o), nxt);
    check({req, " R4 event"}, int'(event_o), int'(ev));
    ext_clk_i = 0;
    @(negedge clk_i);
    check({req, " R4 event low"}, int'(event_o), 0);
    repeat (3) @(negedge clk_i);
    check({req, " R1 falling edge"}, int'(count_o), nxt);
    cnt = nxt;
  endtask

  task automatic do_clear();
    @(negedge clk_i) clear_i = 1;
    @(negedge clk_i) clear_i = 0;
    cnt = 0;
    check("R9 clear", int'(count_o), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R10 reset count", int'(count_o), 0);
    check("R10 reset event", int'(event_o), 0);
    rst_ni = 1;
    @(negedge clk_i);

    // R2 R3 R4 R6: sweep all periods, software bit steers, pin opposite
    for (int p = 0; p <= MAXV; p++) begin
      period_i = W'(p);
      do_clear();
      dir_src_i = 0;
      dir_bit_i = 1; ext_dir_i = 0;
      for (int k = 0; k < 2*(p+1)+1; k++) pulse(1'b1, 1'b1, "R2 R6 up");
      dir_bit_i = 0; ext_dir_i = 1;
      for (int k = 0; k < 2*(p+1)+1; k++) pulse(1'b0, 1'b1, "R3 R6 down");
    end

    // R5: pin steers, bit opposite
    period_i = 4'd5;
    do_clear();
    dir_src_i = 1; dir_bit_i = 0; ext_dir_i = 1;
    repeat (3) @(negedge clk_i);
    for (int k = 0; k < 8; k++) pulse(1'b1, 1'b1, "R5 pin up");
    dir_bit_i = 1; ext_dir_i = 0;
    repeat (3) @(negedge clk_i);
    for (int k = 0; k < 9; k++) pulse(1'b0, 1'b1, "R5 pin down");

    // R7: every non-timer mode holds
    dir_src_i = 0; dir_bit_i = 1;
    for (int m = 0; m < 8; m++) begin
      mode_i = 3'(m);
      pulse(1'b1, m == 1, "R7 mode");
    end

    // R8: switch away and back keeps count
    mode_i = 3'b001;
    pulse(1'b1, 1'b1, "R8 pre");
    mode_i = 3'b110;
    repeat (4) @(negedge clk_i);
    mode_i = 3'b001;
    @(negedge clk_i);
    check("R8 kept", int'(count_o), cnt);
    pulse(1'b1, 1'b1, "R8 resume");

    // R9: clear from nonzero, then clear with simultaneous counted edge
    check("R9 nonzero before", int'(count_o != 0), 1);
    do_clear();
    pulse(1'b1, 1'b1, "R9 after clear");
    @(negedge clk_i) ext_clk_i = 1;
    @(negedge clk_i);
    @(negedge clk_i) clear_i = 1;
    @(negedge clk_i) clear_i = 0;
    check("R9 clear priority", int'(count_o), 0);
    check("R9 clear event", int'(event_o), 0);
    ext_clk_i = 0;
    cnt = 0;
    repeat (4) @(negedge clk_i);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule